// File: doc/BRIEF.md
# Buffered Linked-Pair PWM Generator

This block produces one pulse-width-modulated output from a free-running up-counter. A prescaler divides the clock by a power of two between 1 and 64. The counter runs from zero up to a programmable modulo value, wraps back to zero, and raises a one-cycle wrap flag as it does so. The output is high from the start of each period for as long as the count stays below the compare value of the channel in control. It falls when the count reaches that value. An invert bit can flip the output polarity.

Two compare register sets, channel A and channel B, can be joined into a buffered pair. When the pair is first joined, channel A drives the width. Software then writes new widths into the set that is not in control. At the next wrap, control passes to whichever set was written most recently, so a width change always starts at a period boundary. A write to the set that is in control takes effect at once, as in plain single-channel mode. A status bit tells software which set is in control. A flag shows that the second channel's pin is free for general use while the pair is joined.

Software reaches the block through an 8-bit register bus. To set it up, software halts the counter, clears the counter and prescaler, writes the modulo value and then the compare values, and finally starts the counter.

Top module: `pair_pwm_timer`

## Requirements
- R1: The counter counts from 0 up to the modulo value, then wraps to 0. `wrap_pulse` is high for exactly the one cycle in which the count has just wrapped to 0. The period is therefore (modulo+1) × divide ratio clocks.
- R2: Control bits [7:4] select the divide ratio. Code n gives a ratio of 2^n for n from 0 to 6, and every code from 6 to 15 divides by 64.
- R3: `pwm_out` (with invert off) is high while count < active compare value. A compare value of 0 gives 0 % duty, and any compare value greater than the modulo gives 100 % duty.
- R4: Control bit 3 inverts `pwm_out`.
- R5: While control bit 0 (halt) is set, the counter and prescaler hold their values and no wrap occurs.
- R6: Writing 1 to control bit 1 clears the counter and prescaler in that cycle. After a clear, the next wrap comes (modulo+1) × ratio cycles later. Bit 1 always reads back as 0.
- R7: Control bit 2 joins channels A and B. On joining, channel A is in control. `aux_pin_free` is high while the pair is joined.
- R8: A completed write to the inactive channel does not change the output or `active_sel` until the next wrap. From that wrap on, the written channel is in control.
- R9: At each wrap of a joined pair, the channel whose low byte was written most recently takes control. The status register (address 7) reads bit 0 = active channel (1 = B) and bit 1 = joined.
- R10: A write to the channel in control changes the output from the next cycle, without waiting for a wrap.
- R11: When the pair is not joined, channel A alone sets the width, `active_sel` is 0, and writes to channel B have no effect on the output.
- R12: Address map: 0 control, 1/2 modulo high/low, 3/4 channel A high/low, 5/6 channel B high/low. A 16-bit value is committed only when its low byte is written; a high-byte write alone changes neither the readback nor the behaviour. Reset values are modulo 0xFFFF, compares 0, control 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pwm_out | output | 1 | PWM output |
| aux_pin_free | output | 1 | High while the pair is joined and the second pin is free |
| wrap_pulse | output | 1 | One-cycle flag when the counter wraps to 0 |
| active_sel | output | 1 | Register set in control (0 = A, 1 = B) |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a prescaler that reaches divide-by-64. With these values, the split of each value into two bytes on the 8-bit bus is exercised. The bench also reaches the largest divide ratio and the clamping of the unused select codes. Because the bench writes small modulo values, each period lasts only tens of cycles. This lets it watch control hand over between the two register sets across many wraps, and still includes one 300-cycle period set through a two-byte modulo write.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;
    localparam int SEL_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_MOD_HI = 3'd1,
        RA_MOD_LO = 3'd2,
        RA_A_HI   = 3'd3,
        RA_A_LO   = 3'd4,
        RA_B_HI   = 3'd5,
        RA_B_LO   = 3'd6,
        RA_STATUS = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [SEL_W-1:0] div_sel;
        logic             invert;
        logic             link;
        logic             halt;
    } ctrl_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int MAX_LOG = 6,
    parameter int SEL_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = MAX_LOG;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          st_q, st_d;
    logic [PRE_W-1:0] mask;

    // Low bits that must all be ones for a tick; codes above MAX_LOG saturate.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (int'(sel) > i);
        end
        tick = run && ((st_q.pre & mask) == mask);
        st_d = st_q;
        if (clear) begin
            st_d.pre = '0;
        end else if (run) begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap_evt,
    output logic             wrap_q
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wrap;
    } cnt_st_t;

    cnt_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        wrap_evt  = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (tick) begin
            // >= lets a shortened modulo take effect without a long run-out
            if (st_q.cnt >= mod_val) begin
                st_d.cnt  = '0;
                st_d.wrap = 1'b1;
                wrap_evt  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    assign cnt_nxt = st_d.cnt;
    assign wrap_q  = st_q.wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              active,
    output logic [BUS_W-1:0]  rdata,
    output ctrl_t             ctrl_q,
    output logic              link_nxt,
    output logic              clr_stb,
    output logic              a_commit,
    output logic              b_commit,
    output logic [CNT_W-1:0]  mod_q,
    output logic [CNT_W-1:0]  cmp_a_nxt,
    output logic [CNT_W-1:0]  cmp_b_nxt
);
    localparam int HI_W = CNT_W - BUS_W;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [HI_W-1:0]  mod_hi;
        logic [HI_W-1:0]  a_hi;
        logic [HI_W-1:0]  b_hi;
        logic [CNT_W-1:0] mod;
        logic [CNT_W-1:0] cmp_a;
        logic [CNT_W-1:0] cmp_b;
    } regs_t;

    regs_t q, d;

    function automatic logic [BUS_W-1:0] upper_byte(input logic [CNT_W-1:0] v);
        logic [BUS_W-1:0] r;
        r            = '0;
        r[HI_W-1:0]  = v[CNT_W-1:BUS_W];
        return r;
    endfunction

    // Write side: high bytes only stage, low bytes commit the full value.
    always_comb begin
        d        = q;
        clr_stb  = 1'b0;
        a_commit = 1'b0;
        b_commit = 1'b0;
        if (we) begin
            case (reg_addr_e'(addr))
                RA_CTRL: begin
                    d.ctrl.div_sel = wdata[BUS_W-1 -: SEL_W];
                    d.ctrl.invert  = wdata[3];
                    d.ctrl.link    = wdata[2];
                    d.ctrl.halt    = wdata[0];
                    clr_stb        = wdata[1];
                end
                RA_MOD_HI: d.mod_hi = wdata[HI_W-1:0];
                RA_MOD_LO: d.mod    = {q.mod_hi, wdata};
                RA_A_HI:   d.a_hi   = wdata[HI_W-1:0];
                RA_A_LO: begin
                    d.cmp_a  = {q.a_hi, wdata};
                    a_commit = 1'b1;
                end
                RA_B_HI:   d.b_hi   = wdata[HI_W-1:0];
                RA_B_LO: begin
                    d.cmp_b  = {q.b_hi, wdata};
                    b_commit = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Read side: committed values only.
    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_CTRL:   rdata = {q.ctrl.div_sel, q.ctrl.invert, q.ctrl.link, 1'b0, q.ctrl.halt};
            RA_MOD_HI: rdata = upper_byte(q.mod);
            RA_MOD_LO: rdata = q.mod[BUS_W-1:0];
            RA_A_HI:   rdata = upper_byte(q.cmp_a);
            RA_A_LO:   rdata = q.cmp_a[BUS_W-1:0];
            RA_B_HI:   rdata = upper_byte(q.cmp_b);
            RA_B_LO:   rdata = q.cmp_b[BUS_W-1:0];
            RA_STATUS: begin
                rdata[0] = active;
                rdata[1] = q.ctrl.link;
            end
            default:   rdata = '0;
        endcase
    end

    assign ctrl_q    = q.ctrl;
    assign link_nxt  = d.ctrl.link;
    assign mod_q     = q.mod;
    assign cmp_a_nxt = d.cmp_a;
    assign cmp_b_nxt = d.cmp_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl   <= '0;
            q.mod_hi <= '0;
            q.a_hi   <= '0;
            q.b_hi   <= '0;
            q.mod    <= '1;
            q.cmp_a  <= '0;
            q.cmp_b  <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/pwm_pair_select.sv
module pwm_pair_select #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_q,
    input  logic             link_nxt,
    input  logic             a_commit,
    input  logic             b_commit,
    input  logic             wrap_evt,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] cmp_a_nxt,
    input  logic [CNT_W-1:0] cmp_b_nxt,
    output logic             active_q,
    output logic             pwm_q
);
    typedef struct packed {
        logic last;    // set written most recently (1 = B)
        logic active;  // set in control (1 = B)
        logic pwm;     // registered raw compare result
    } sel_st_t;

    sel_st_t          st_q, st_d;
    logic [CNT_W-1:0] cmp_sel;

    always_comb begin
        st_d = st_q;
        if (!link_nxt || !link_q) begin
            // unjoined, or joining this cycle: channel A owns the output
            st_d.last   = 1'b0;
            st_d.active = 1'b0;
        end else begin
            if (b_commit) begin
                st_d.last = 1'b1;
            end else if (a_commit) begin
                st_d.last = 1'b0;
            end
            if (wrap_evt) begin
                st_d.active = st_d.last;
            end
        end
        cmp_sel    = st_d.active ? cmp_b_nxt : cmp_a_nxt;
        st_d.pwm   = (cnt_nxt < cmp_sel);
    end

    assign active_q = st_q.active;
    assign pwm_q    = st_q.pwm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pair_pwm_timer.sv
module pair_pwm_timer
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MAX_LOG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              pwm_out,
    output logic              aux_pin_free,
    output logic              wrap_pulse,
    output logic              active_sel
);
    ctrl_t            ctrl_q;
    logic             link_nxt;
    logic             clr_stb;
    logic             a_commit;
    logic             b_commit;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] cmp_a_nxt;
    logic [CNT_W-1:0] cmp_b_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             tick;
    logic             wrap_evt;
    logic             pwm_raw;

    pwm_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .active    (active_sel),
        .rdata     (bus_rdata),
        .ctrl_q    (ctrl_q),
        .link_nxt  (link_nxt),
        .clr_stb   (clr_stb),
        .a_commit  (a_commit),
        .b_commit  (b_commit),
        .mod_q     (mod_q),
        .cmp_a_nxt (cmp_a_nxt),
        .cmp_b_nxt (cmp_b_nxt)
    );

    pwm_prescaler #(.MAX_LOG(MAX_LOG), .SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!ctrl_q.halt),
        .clear (clr_stb),
        .sel   (ctrl_q.div_sel),
        .tick  (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clear    (clr_stb),
        .mod_val  (mod_q),
        .cnt_nxt  (cnt_nxt),
        .wrap_evt (wrap_evt),
        .wrap_q   (wrap_pulse)
    );

    pwm_pair_select #(.CNT_W(CNT_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_q    (ctrl_q.link),
        .link_nxt  (link_nxt),
        .a_commit  (a_commit),
        .b_commit  (b_commit),
        .wrap_evt  (wrap_evt),
        .cnt_nxt   (cnt_nxt),
        .cmp_a_nxt (cmp_a_nxt),
        .cmp_b_nxt (cmp_b_nxt),
        .active_q  (active_sel),
        .pwm_q     (pwm_raw)
    );

    assign pwm_out      = pwm_raw ^ ctrl_q.invert;
    assign aux_pin_free = ctrl_q.link;

endmodule

// File: rtl/pwm_pair_checker.sv
module pwm_pair_checker (
    input logic clk,
    input logic rst_n,
    input logic halt,
    input logic clr_stb,
    input logic wrap_pulse,
    input logic aux_pin_free,
    input logic active_sel
);

    AST_NO_WRAP_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !wrap_pulse); // R5

    AST_NO_WRAP_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> !wrap_pulse); // R6

    AST_HANDOVER_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_pin_free && $past(aux_pin_free) && (active_sel != $past(active_sel))) |-> wrap_pulse); // R8

    AST_UNJOINED_USES_A: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_pin_free |-> !active_sel); // R11

endmodule

bind pair_pwm_timer pwm_pair_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt         (ctrl_q.halt),
    .clr_stb      (clr_stb),
    .wrap_pulse   (wrap_pulse),
    .aux_pin_free (aux_pin_free),
    .active_sel   (active_sel)
);

// File: tb/pair_pwm_timer_test.sv
module pair_pwm_timer_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] AD_CTRL = 3'd0, AD_MOD = 3'd1, AD_A = 3'd3, AD_B = 3'd5, AD_STAT = 3'd7;
    localparam logic [7:0] C_HALT = 8'h01, C_CLR = 8'h02, C_LINK = 8'h04, C_INV = 8'h08;

    // stimulus: divide code, modulo, compare; expected: period, high cycles
    localparam int NV = 10;
    localparam int V_SEL [NV] = '{0, 0, 0, 1, 2, 3, 6, 7, 0, 0};
    localparam int V_MOD [NV] = '{9, 9, 9, 4, 3, 2, 1, 1, 0, 5};
    localparam int V_CMP [NV] = '{3, 0, 12, 2, 1, 2, 1, 1, 1, 5};
    localparam int V_LEN [NV] = '{10, 10, 10, 10, 16, 24, 128, 128, 1, 6};
    localparam int V_HI  [NV] = '{3, 0, 10, 4, 4, 16, 64, 64, 1, 5};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pwm_out, aux_pin_free, wrap_pulse, active_sel;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    pair_pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out),
        .aux_pin_free(aux_pin_free), .wrap_pulse(wrap_pulse), .active_sel(active_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] hi_addr, input logic [15:0] v);
        wr(hi_addr, v[15:8]);
        wr(hi_addr + 3'd1, v[7:0]);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // Waits for a wrap, then measures length and high cycles up to the next wrap.
    task automatic measure(output int len, output int hi);
        int guard = 0;
        while (!wrap_pulse && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        len = 0; hi = 0;
        do begin
            if (pwm_out) hi++;
            len++;
            @(negedge clk);
        end while (!wrap_pulse && len < 2000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int len, hi, n;
        logic [7:0] rv;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check(pwm_out == 1'b0, "R3 reset output", int'(pwm_out), 0);
        check(active_sel == 1'b0, "R11 reset active", int'(active_sel), 0);
        check(aux_pin_free == 1'b0, "R7 reset free pin", int'(aux_pin_free), 0);
        check(wrap_pulse == 1'b0, "R1 reset wrap", int'(wrap_pulse), 0);
        rd(AD_CTRL, rv);
        check(rv == 8'h00, "R12 reset control", int'(rv), 0);
        rd(AD_MOD, rv);
        check(rv == 8'hFF, "R12 reset modulo", int'(rv), 255);

        // vector table: R1 R2 R3
        for (int k = 0; k < NV; k++) begin
            wr(AD_CTRL, C_HALT | C_CLR);
            wr16(AD_MOD, 16'(V_MOD[k]));
            wr16(AD_A, 16'(V_CMP[k]));
            wr(AD_CTRL, 8'(V_SEL[k] << 4));
            measure(len, hi);
            check(len == V_LEN[k], $sformatf("R1 R2 period vector %0d", k), len, V_LEN[k]);
            check(hi == V_HI[k], $sformatf("R3 high time vector %0d", k), hi, V_HI[k]);
            if (V_LEN[k] > 1) begin
                @(negedge clk);
                check(wrap_pulse == 1'b0, $sformatf("R1 one-cycle wrap vector %0d", k), int'(wrap_pulse), 0);
            end
        end

        // joined pair
        wr(AD_CTRL, C_HALT | C_CLR);
        wr16(AD_MOD, 16'd19);
        wr16(AD_A, 16'd3);
        wr(AD_CTRL, C_LINK);
        check(aux_pin_free == 1'b1, "R7 free pin when joined", int'(aux_pin_free), 1);
        check(active_sel == 1'b0, "R7 A in control on join", int'(active_sel), 0);
        measure(len, hi);
        check(hi == 3, "R7 width from A", hi, 3);
        wr16(AD_B, 16'd7);
        check(active_sel == 1'b0, "R8 no switch before wrap", int'(active_sel), 0);
        measure(len, hi);
        check(hi == 7, "R8 width from B after wrap", hi, 7);
        check(active_sel == 1'b1, "R8 B in control", int'(active_sel), 1);
        rd(AD_STAT, rv);
        check(rv == 8'h03, "R9 status joined and B", int'(rv), 3);

        wr16(AD_A, 16'd2);
        wr16(AD_B, 16'd6);
        measure(len, hi);
        check(hi == 6, "R9 last written B keeps control", hi, 6);
        check(active_sel == 1'b1, "R9 active B", int'(active_sel), 1);
        wr16(AD_B, 16'd5);
        wr16(AD_A, 16'd4);
        measure(len, hi);
        check(hi == 4, "R9 last written A takes control", hi, 4);
        check(active_sel == 1'b0, "R9 active A", int'(active_sel), 0);

        // immediate write to active set while halted at count 0
        wr(AD_CTRL, C_HALT | C_CLR | C_LINK);
        wr16(AD_A, 16'd0);
        check(pwm_out == 1'b0, "R10 active zero width at once", int'(pwm_out), 0);
        wr16(AD_A, 16'd4);
        check(pwm_out == 1'b1, "R10 active write at once", int'(pwm_out), 1);
        wr16(AD_B, 16'd0);
        check(pwm_out == 1'b1, "R8 inactive write no effect", int'(pwm_out), 1);
        check(active_sel == 1'b0, "R8 no switch while halted", int'(active_sel), 0);

        // halt holds everything
        n = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (wrap_pulse || !pwm_out) n++;
        end
        check(n == 0, "R5 halted no wrap no change", n, 0);

        // clear then timing to first wrap at divide by 4
        wr(AD_CTRL, C_LINK | C_CLR | 8'h20);
        n = 0;
        while (!wrap_pulse && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n == 80, "R6 first wrap after clear", n, 80);
        rd(AD_CTRL, rv);
        check(rv == 8'h24, "R6 clear bit reads zero", int'(rv), 36);

        // invert, unjoined, A = 4
        wr(AD_CTRL, C_HALT | C_CLR);
        wr(AD_CTRL, C_INV);
        measure(len, hi);
        check(hi == 16, "R4 inverted high time", hi, 16);

        // unjoined: B ignored
        wr(AD_CTRL, 8'h00);
        wr16(AD_B, 16'd11);
        measure(len, hi);
        check(hi == 4, "R11 B ignored when unjoined", hi, 4);
        measure(len, hi);
        check(hi == 4, "R11 B ignored second period", hi, 4);
        check(active_sel == 1'b0 && aux_pin_free == 1'b0, "R11 A active pin not free",
              int'({aux_pin_free, active_sel}), 0);

        // byte commit
        wr(AD_MOD, 8'h01);
        rd(AD_MOD, rv);
        check(rv == 8'h00, "R12 high byte alone not committed", int'(rv), 0);
        measure(len, hi);
        check(len == 20, "R12 period unchanged by high byte", len, 20);
        wr(AD_MOD + 3'd1, 8'h2B);
        rd(AD_MOD, rv);
        check(rv == 8'h01, "R12 high byte after low write", int'(rv), 1);
        measure(len, hi);
        check(len == 300, "R12 committed 16-bit modulo", len, 300);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule